// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the finite-state controller that steps a multi-cycle processor datapath through each instruction. Every instruction is broken into short steps of one clock each. The controller holds the current step and drives all datapath write enables, multiplexer selects and the ALU operation for that step. Its only data input is the 6-bit opcode field of the instruction register.

The controller handles five instruction classes. Register-register arithmetic, or-immediate and compare-and-branch each take four, four and three cycles. Word load takes five cycles and word store takes four. The decode step always adds the scaled, sign-extended offset to the incremented program counter and saves the result as a branch target. This happens before the opcode is examined, so a taken branch needs no extra cycle.

In a store, the memory write enable is raised only in the step after the address was computed. The operand selects stay the same across both steps, so the address is settled before the enable rises. The execute and finish steps of the arithmetic classes also keep identical selects, so the ALU result stays steady until it is written back. All outputs depend on the current step alone (Moore style). A select that a step does not use is driven to 0.

Top module: `mcc_seq_ctrl`

## Requirements
- R1: While reset (active low `rst_n`) is asserted, and in the first cycle after it is released, the outputs show the fetch step.
- R2: Fetch step: `pc_we`=1, `ir_we`=1, `alu_op`=00 (add), `alu_b_sel`=00 (constant four), `alu_a_sel`=0. Every other output is 0.
- R3: Decode step, which always follows fetch: `tgt_we`=1, `imm_sign`=1, `alu_op`=00, `alu_a_sel`=0, `alu_b_sel`=10 (offset shifted left by two). Every other output is 0.
- R4: After decode, the next step depends on the opcode. Opcode 100011 (load) and 101011 (store) go to address-calc. Opcode 000000 goes to register-execute, 001101 to immediate-execute and 000100 to branch-complete.
- R5: Branch-complete step: `pc_we_cond`=1, `pc_src`=1, `alu_op`=01 (subtract), `alu_a_sel`=1, `alu_b_sel`=01 (register B). Every other output is 0.
- R6: Register-execute step: `alu_op`=10 (function field), `alu_a_sel`=1, `alu_b_sel`=01, `dst_sel_rd`=1. The register-finish step that follows has the same values plus `rf_we`=1, with `wb_sel_mem`=0.
- R7: Immediate-execute step: `alu_op`=11 (or), `alu_a_sel`=1, `alu_b_sel`=11 (extended immediate), `imm_sign`=0, `dst_sel_rd`=0. The immediate-finish step that follows has the same values plus `rf_we`=1.
- R8: Address-calc step: `alu_op`=00, `alu_a_sel`=1, `alu_b_sel`=11, `imm_sign`=1. For a store, the step that follows has the same values plus `mem_we`=1. This puts the write enable one cycle after the address settles.
- R9: For a load, address-calc is followed by load-memory, which has the address-calc values plus `addr_sel_data`=1. Load-memory is followed by load-writeback, which has the address-calc values plus `rf_we`=1 and `wb_sel_mem`=1. A load therefore takes five cycles.
- R10: Every terminal step (branch-complete, register-finish, immediate-finish, store-memory, load-writeback) is followed by fetch.
- R11: Any other opcode seen in decode returns the controller to fetch. No register, memory or target write takes place on the way.
- R12: In every step, at most one of `pc_we`, `pc_we_cond`, `tgt_we`, `mem_we` and `rf_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write if the ALU result is zero |
| ir_we | output | 1 | Instruction register write |
| tgt_we | output | 1 | Branch target register write |
| mem_we | output | 1 | Memory write enable |
| rf_we | output | 1 | Register file write enable |
| addr_sel_data | output | 1 | Memory address from ALU result (1) or program counter (0) |
| pc_src | output | 1 | Program counter source: target register (1) or ALU (0) |
| dst_sel_rd | output | 1 | Destination register field: rd (1) or rt (0) |
| wb_sel_mem | output | 1 | Write-back data: memory (1) or ALU (0) |
| imm_sign | output | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| alu_a_sel | output | 1 | ALU A: register A (1) or program counter (0) |
| alu_b_sel | output | 2 | ALU B: 00 four, 01 register B, 10 shifted offset, 11 immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 or |

## Verification
The assertions assume the opcode does not change from the decode step until the instruction's terminal step. In a real datapath the instruction register is written only at the end of fetch. The bench therefore changes the opcode only while the fetch step is showing. It sweeps all 64 opcode values in this way, compares every step of every instruction against the step values listed in the requirements, and also applies a reset in the middle of an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;
    localparam int SEL_W = 2;
    localparam int AOP_W = 2;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_BR_DONE,
        ST_R_EXEC,
        ST_R_DONE,
        ST_I_EXEC,
        ST_I_DONE,
        ST_ADDR,
        ST_ST_MEM,
        ST_LD_MEM,
        ST_LD_WB
    } step_e;

    localparam logic [AOP_W-1:0] AOP_ADD  = 2'b00;
    localparam logic [AOP_W-1:0] AOP_SUB  = 2'b01;
    localparam logic [AOP_W-1:0] AOP_FUNC = 2'b10;
    localparam logic [AOP_W-1:0] AOP_OR   = 2'b11;

    localparam logic [SEL_W-1:0] BSEL_FOUR = 2'b00;
    localparam logic [SEL_W-1:0] BSEL_REG  = 2'b01;
    localparam logic [SEL_W-1:0] BSEL_OFS  = 2'b10;
    localparam logic [SEL_W-1:0] BSEL_IMM  = 2'b11;

    typedef struct packed {
        logic              pc_we;
        logic              pc_we_cond;
        logic              ir_we;
        logic              tgt_we;
        logic              mem_we;
        logic              rf_we;
        logic              addr_sel_data;
        logic              pc_src;
        logic              dst_sel_rd;
        logic              wb_sel_mem;
        logic              imm_sign;
        logic              alu_a_sel;
        logic [SEL_W-1:0]  alu_b_sel;
        logic [AOP_W-1:0]  alu_op;
    } ctrl_t;

    typedef struct packed {
        step_e step;
    } seq_t;

endpackage

// File: rtl/mcc_dispatch.sv
module mcc_dispatch
    import mcc_pkg::*;
#(
    parameter int                OP_W     = OPC_W,
    parameter logic [OP_W-1:0]   OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0]   OP_ORI   = 6'b001101,
    parameter logic [OP_W-1:0]   OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0]   OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0]   OP_BEQ   = 6'b000100
) (
    input  logic [OP_W-1:0] opcode,
    output step_e           target_step,
    output logic            is_store
);
    always_comb begin
        target_step = ST_FETCH;
        is_store    = 1'b0;
        if (opcode == OP_LOAD) begin
            target_step = ST_ADDR;
        end else if (opcode == OP_STORE) begin
            target_step = ST_ADDR;
            is_store    = 1'b1;
        end else if (opcode == OP_RTYPE) begin
            target_step = ST_R_EXEC;
        end else if (opcode == OP_ORI) begin
            target_step = ST_I_EXEC;
        end else if (opcode == OP_BEQ) begin
            target_step = ST_BR_DONE;
        end
    end
endmodule

// File: rtl/mcc_step_next.sv
module mcc_step_next
    import mcc_pkg::*;
(
    input  seq_t  cur,
    input  step_e dispatch_step,
    input  logic  dispatch_store,
    output seq_t  nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur.step)
            ST_FETCH:   nxt.step = ST_DECODE;
            ST_DECODE:  nxt.step = dispatch_step;
            ST_R_EXEC:  nxt.step = ST_R_DONE;
            ST_I_EXEC:  nxt.step = ST_I_DONE;
            ST_ADDR:    nxt.step = dispatch_store ? ST_ST_MEM : ST_LD_MEM;
            ST_LD_MEM:  nxt.step = ST_LD_WB;
            ST_BR_DONE, ST_R_DONE, ST_I_DONE, ST_ST_MEM, ST_LD_WB:
                        nxt.step = ST_FETCH;
            default:    nxt.step = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  step_e step,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (step)
            ST_FETCH: begin
                ctrl.pc_we     = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.alu_op    = AOP_ADD;
                ctrl.alu_b_sel = BSEL_FOUR;
            end
            ST_DECODE: begin
                ctrl.tgt_we    = 1'b1;
                ctrl.imm_sign  = 1'b1;
                ctrl.alu_op    = AOP_ADD;
                ctrl.alu_b_sel = BSEL_OFS;
            end
            ST_BR_DONE: begin
                ctrl.pc_we_cond = 1'b1;
                ctrl.pc_src     = 1'b1;
                ctrl.alu_op     = AOP_SUB;
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = BSEL_REG;
            end
            ST_R_EXEC, ST_R_DONE: begin
                ctrl.alu_op     = AOP_FUNC;
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = BSEL_REG;
                ctrl.dst_sel_rd = 1'b1;
                ctrl.rf_we      = (step == ST_R_DONE);
            end
            ST_I_EXEC, ST_I_DONE: begin
                ctrl.alu_op    = AOP_OR;
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSEL_IMM;
                ctrl.rf_we     = (step == ST_I_DONE);
            end
            ST_ADDR, ST_ST_MEM, ST_LD_MEM, ST_LD_WB: begin
                ctrl.alu_op        = AOP_ADD;
                ctrl.alu_a_sel     = 1'b1;
                ctrl.alu_b_sel     = BSEL_IMM;
                ctrl.imm_sign      = 1'b1;
                ctrl.mem_we        = (step == ST_ST_MEM);
                ctrl.addr_sel_data = (step == ST_LD_MEM);
                ctrl.rf_we         = (step == ST_LD_WB);
                ctrl.wb_sel_mem    = (step == ST_LD_WB);
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/mcc_seq_ctrl.sv
module mcc_seq_ctrl
    import mcc_pkg::*;
#(
    parameter int              OP_W     = OPC_W,
    parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
    parameter logic [OP_W-1:0] OP_ORI   = 6'b001101,
    parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE = 6'b101011,
    parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    output logic             pc_we,
    output logic             pc_we_cond,
    output logic             ir_we,
    output logic             tgt_we,
    output logic             mem_we,
    output logic             rf_we,
    output logic             addr_sel_data,
    output logic             pc_src,
    output logic             dst_sel_rd,
    output logic             wb_sel_mem,
    output logic             imm_sign,
    output logic             alu_a_sel,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [AOP_W-1:0] alu_op
);
    seq_t  seq_d, seq_q;
    step_e disp_step;
    logic  disp_store;
    ctrl_t ctrl;

    mcc_dispatch #(
        .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_ORI(OP_ORI),
        .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)
    ) u_dispatch (
        .opcode      (opcode),
        .target_step (disp_step),
        .is_store    (disp_store)
    );

    mcc_step_next u_next (
        .cur            (seq_q),
        .dispatch_step  (disp_step),
        .dispatch_store (disp_store),
        .nxt            (seq_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{step: ST_FETCH};
        else        seq_q <= seq_d;
    end

    mcc_ctrl_decode u_decode (
        .step (seq_q.step),
        .ctrl (ctrl)
    );

    assign pc_we         = ctrl.pc_we;
    assign pc_we_cond    = ctrl.pc_we_cond;
    assign ir_we         = ctrl.ir_we;
    assign tgt_we        = ctrl.tgt_we;
    assign mem_we        = ctrl.mem_we;
    assign rf_we         = ctrl.rf_we;
    assign addr_sel_data = ctrl.addr_sel_data;
    assign pc_src        = ctrl.pc_src;
    assign dst_sel_rd    = ctrl.dst_sel_rd;
    assign wb_sel_mem    = ctrl.wb_sel_mem;
    assign imm_sign      = ctrl.imm_sign;
    assign alu_a_sel     = ctrl.alu_a_sel;
    assign alu_b_sel     = ctrl.alu_b_sel;
    assign alu_op        = ctrl.alu_op;

    logic op_known;
    assign op_known = (opcode == OP_RTYPE) || (opcode == OP_ORI) ||
                      (opcode == OP_LOAD)  || (opcode == OP_STORE) ||
                      (opcode == OP_BEQ);

    // R8: store write enable follows a cycle with identical address selects
    p_store_after_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(alu_b_sel) == BSEL_IMM && $past(imm_sign) &&
                    $past(alu_a_sel) && !$past(mem_we)));

    // R9: memory write-back is preceded by the data-memory read step
    p_load_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_sel_mem |-> $past(addr_sel_data));

    // R6: register-type finish preceded by execute with same selects
    p_rfinish_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && dst_sel_rd) |-> ($past(alu_op) == AOP_FUNC && !$past(rf_we)));

    // R10: terminal steps return to fetch
    p_term_to_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we_cond || mem_we || rf_we) |=> (ir_we && pc_we));

    // R11: unknown opcode in decode returns to fetch
    p_unknown_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.step == ST_DECODE && !op_known) |=> seq_q.step == ST_FETCH);

    // R3: decode always follows fetch
    p_fetch_to_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> tgt_we);

    // R12: at most one state write per step
    p_one_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_we, pc_we_cond, tgt_we, mem_we, rf_we}));

endmodule

// File: tb/mcc_seq_ctrl_bench.sv
module mcc_seq_ctrl_bench;
    localparam time HALF = 2.5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic pc_we, pc_we_cond, ir_we, tgt_we, mem_we, rf_we;
    logic addr_sel_data, pc_src, dst_sel_rd, wb_sel_mem, imm_sign, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(HALF) clk = ~clk;

    mcc_seq_ctrl u_mcc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .ir_we(ir_we), .tgt_we(tgt_we),
        .mem_we(mem_we), .rf_we(rf_we), .addr_sel_data(addr_sel_data),
        .pc_src(pc_src), .dst_sel_rd(dst_sel_rd), .wb_sel_mem(wb_sel_mem),
        .imm_sign(imm_sign), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op)
    );

    // word: {pc_we,pc_we_cond,ir_we,tgt_we,mem_we,rf_we,addr_sel_data,pc_src,
    //        dst_sel_rd,wb_sel_mem,imm_sign,alu_a_sel,alu_b_sel[1:0],alu_op[1:0]}
    function automatic logic [15:0] mk(input bit pw, pwc, irw, tw, mw, rw,
                                       asd, ps, dr, wm, isg, asel,
                                       input logic [1:0] bsel, aop);
        return {pw, pwc, irw, tw, mw, rw, asd, ps, dr, wm, isg, asel, bsel, aop};
    endfunction

    // step codes: 0 fetch 1 decode 2 branch 3 rexec 4 rdone 5 iexec 6 idone
    //             7 addr 8 stmem 9 ldmem 10 ldwb
    function automatic logic [15:0] exp_word(input int s);
        case (s)
            0:  return mk(1,0,1,0,0,0,0,0,0,0,0,0,2'b00,2'b00);
            1:  return mk(0,0,0,1,0,0,0,0,0,0,1,0,2'b10,2'b00);
            2:  return mk(0,1,0,0,0,0,0,1,0,0,0,1,2'b01,2'b01);
            3:  return mk(0,0,0,0,0,0,0,0,1,0,0,1,2'b01,2'b10);
            4:  return mk(0,0,0,0,0,1,0,0,1,0,0,1,2'b01,2'b10);
            5:  return mk(0,0,0,0,0,0,0,0,0,0,0,1,2'b11,2'b11);
            6:  return mk(0,0,0,0,0,1,0,0,0,0,0,1,2'b11,2'b11);
            7:  return mk(0,0,0,0,0,0,0,0,0,0,1,1,2'b11,2'b00);
            8:  return mk(0,0,0,0,1,0,0,0,0,0,1,1,2'b11,2'b00);
            9:  return mk(0,0,0,0,0,0,1,0,0,0,1,1,2'b11,2'b00);
            default: return mk(0,0,0,0,0,1,0,0,0,1,1,1,2'b11,2'b00);
        endcase
    endfunction

    function automatic logic [15:0] got();
        return {pc_we, pc_we_cond, ir_we, tgt_we, mem_we, rf_we, addr_sel_data,
                pc_src, dst_sel_rd, wb_sel_mem, imm_sign, alu_a_sel, alu_b_sel, alu_op};
    endfunction

    task automatic check(input string req, input int s, input logic [5:0] op);
        n_checks++;
        if (got() !== exp_word(s)) begin
            n_errors++;
            $display("FAIL %s op=%b step=%0d actual=%b expected=%b",
                     req, op, s, got(), exp_word(s));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // expected step list for one instruction, from fetch to terminal step
    function automatic int seq_len(input logic [5:0] op);
        case (op)
            6'b100011: return 5;
            6'b101011, 6'b000000, 6'b001101: return 4;
            6'b000100: return 3;
            default:   return 2;
        endcase
    endfunction

    function automatic int seq_step(input logic [5:0] op, input int k);
        if (k == 0) return 0;
        if (k == 1) return 1;
        case (op)
            6'b100011: return (k == 2) ? 7 : (k == 3) ? 9 : 10;
            6'b101011: return (k == 2) ? 7 : 8;
            6'b000000: return (k == 2) ? 3 : 4;
            6'b001101: return (k == 2) ? 5 : 6;
            default:   return 2;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input int k);
        if (k == 0) return "R2/R10";
        if (k == 1) return "R3";
        case (op)
            6'b100011: return (k == 2) ? "R4/R8" : "R9";
            6'b101011: return (k == 2) ? "R4/R8" : "R8";
            6'b000000: return (k == 2) ? "R4/R6" : "R6";
            6'b001101: return (k == 2) ? "R4/R7" : "R7";
            default:   return "R5";
        endcase
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: fetch outputs while in reset
        #3;
        check("R1", 0, opcode);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 0, opcode);

        // sweep all opcodes back to back; opcode changes only during fetch
        for (int op = 0; op < 64; op++) begin
            logic [5:0] o;
            o = 6'(op);
            opcode = o;
            for (int k = 0; k < seq_len(o); k++) begin
                if (seq_len(o) == 2 && k == 1) begin
                    check("R3/R11", 1, o);
                end else begin
                    check(req_of(o, k), seq_step(o, k), o);
                end
                // R12: never two state writes at once
                n_checks++;
                if ($countones({pc_we, pc_we_cond, tgt_we, mem_we, rf_we}) > 1) begin
                    n_errors++;
                    $display("FAIL R12 op=%b actual=%b expected=onehot0", o, got());
                end
                tick();
            end
            // R10/R11: the next step is fetch again
            check(seq_len(o) == 2 ? "R11" : "R10", 0, o);
        end

        // R1: reset in the middle of a register-type instruction
        opcode = 6'b000000;
        tick();
        tick();
        check("R6", 3, opcode);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 0, opcode);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 0, opcode);
        tick();
        check("R3", 1, opcode);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule